// File: doc/BRIEF.md
# Banked Architectural Register File

This block holds the sixteen architectural registers of a small microcontroller core. Two combinational read ports and one write port serve the execution pipeline. Entries 0 to 12 are plain 32-bit data registers. Entry 14 is the link register. Entry 15 is not stored: a read returns the fetch address plus one word, and a write is turned into a branch request or a fault strobe.

Entry 13 is the stack pointer. It is backed by two physical copies, a main copy and a process copy. A registered select decides which copy the normal ports see. A side port for special-register moves reads or writes either copy directly, whatever the select. The word-alignment bits of both copies are always zero.

A built-in stack unit performs single-word push and pop through a request/acknowledge memory handshake. The stack grows downward and the pointer addresses the last filled word. The unit locks onto the copy that was active when the operation started. When its pointer update collides with another write to the same copy, the update takes priority.

Top module: `banked_regfile`

## Requirements
- R1: After reset the select holds the main copy (select value 0; 1 is the process copy). The main copy holds MAIN_INIT and the process copy holds PROC_INIT. A read of index 13 then returns MAIN_INIT.
- R2: A write to any index 0 to 12 or 14 can be read on both read ports from the cycle after the write edge. Bit 0 of index 14 is stored and returned like any other bit.
- R3: Index 13 on the read and write ports maps to the copy chosen by `sp_sel`. A change of `sp_sel` takes effect only at the next rising clock edge.
- R4: The side port reads the copy named by `sys_rsel` combinationally. It writes the copy named by `sys_wsel` at the clock edge, independent of the select. The other copy is left untouched.
- R5: Bits 1:0 of both stack pointer copies read as zero, whatever value was written through either port.
- R6: A push presents a memory write at the active pointer minus 4, carrying the push data. When the write is acknowledged, the pointer becomes that address.
- R7: A pop presents a memory read at the active pointer. In the acknowledge cycle `pop_valid` is high and `pop_data` carries the read word. After that cycle the pointer has grown by 4.
- R8: A push or pop finishes on the copy that was active when it was accepted, even if the select changes while it waits. The memory request keeps its address and direction stable until acknowledged.
- R9: If the pointer update of a completing push or pop hits the same copy as a normal write or a side-port write in that cycle, the pointer update wins.
- R10: A read of index 15 returns `pc_in + 4` with bit 0 forced to 0.
- R11: A write to index 15 with data bit 0 = 1 raises `br_valid` for one cycle after the edge. `br_target` equals the data with bit 0 cleared, and the link register keeps its value.
- R12: A write to index 15 with data bit 0 = 0 raises `br_fault` for one cycle after the edge. `br_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_sel | input | 1 | Stack copy select, 0 main, 1 process; sampled at the edge |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| pc_in | input | 32 | Address of the executing instruction |
| br_valid | output | 1 | Branch request strobe |
| br_target | output | 32 | Branch target, bit 0 cleared |
| br_fault | output | 1 | Bad branch target strobe |
| sys_rsel | input | 1 | Side-port read copy, 0 main, 1 process |
| sys_rdata | output | 32 | Side-port read data |
| sys_we | input | 1 | Side-port write enable |
| sys_wsel | input | 1 | Side-port write copy |
| sys_wdata | input | 32 | Side-port write data |
| stk_push | input | 1 | Start a push (taken when idle) |
| stk_pop | input | 1 | Start a pop (taken when idle, push has priority) |
| stk_wdata | input | 32 | Word to push |
| stk_busy | output | 1 | Push or pop in progress |
| pop_valid | output | 1 | Popped word valid |
| pop_data | output | 32 | Popped word |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Stack memory address |
| mem_wdata | output | 32 | Stack memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |

## Verification
The hardest situations to reach from the ports are those where a stack operation's pointer update lands in the same cycle as another write to that copy, or after the select has already moved to the other copy. The stimulus uses a bench memory model with a fixed one-cycle acknowledge. This makes the completion cycle known in advance. The bench drives a normal write and a side-port write to index 13 exactly in that cycle, and in another run it flips the select while the request is outstanding. It then reads both copies back through the side port.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
   typedef enum logic {
      BANK_MAIN = 1'b0,
      BANK_PROC = 1'b1
   } sp_bank_e;

   typedef enum logic {
      STK_IDLE = 1'b0,
      STK_BUSY = 1'b1
   } stk_state_e;
endpackage

// File: rtl/banked_rf_store.sv
module banked_rf_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NREG   = 16,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned SP_IDX = 13,
   parameter int unsigned PC_IDX = 15
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_idx,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [1:0][ADDR_W-1:0]       rd_idx,
   output logic [1:0][DATA_W-1:0]       rd_val
);
   logic [DATA_W-1:0] ent [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      if (i == SP_IDX || i == PC_IDX) begin : g_none
         assign ent[i] = '0;
      end else begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == ADDR_W'(i)) q <= wr_data;
         end
         assign ent[i] = q;
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      assign rd_val[p] = ent[rd_idx[p]];
   end
endmodule

// File: rtl/banked_rf_sp.sv
module banked_rf_sp #(
   parameter int unsigned          DATA_W    = 32,
   parameter int unsigned          ALIGN_W   = 2,
   parameter logic [DATA_W-1:0]    MAIN_INIT = '0,
   parameter logic [DATA_W-1:0]    PROC_INIT = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_q,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     sys_we,
   input  logic                     sys_wsel,
   input  logic [DATA_W-1:0]        sys_wdata,
   input  logic                     adj_en,
   input  logic                     adj_bank,
   input  logic [DATA_W-1:0]        adj_val,
   output logic [1:0][DATA_W-1:0]   sp_q
);
   localparam logic [DATA_W-1:0] KEEP_MASK = ~DATA_W'((1 << ALIGN_W) - 1);

   for (genvar b = 0; b < 2; b++) begin : g_bank
      localparam logic [DATA_W-1:0] INIT = (b == 0) ? MAIN_INIT : PROC_INIT;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= INIT & KEEP_MASK;
         end else if (adj_en && adj_bank == 1'(b)) begin
            q <= adj_val & KEEP_MASK;
         end else if (sys_we && sys_wsel == 1'(b)) begin
            q <= sys_wdata & KEEP_MASK;
         end else if (wr_en && sel_q == 1'(b)) begin
            q <= wr_data & KEEP_MASK;
         end
      end
      assign sp_q[b] = q;
   end
endmodule

// File: rtl/banked_rf_stack.sv
module banked_rf_stack
   import banked_rf_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     pop,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     sel_q,
   input  logic [1:0][DATA_W-1:0]   sp_q,
   input  logic                     mem_ack,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic                     busy,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [DATA_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]        mem_wdata,
   output logic                     adj_en,
   output logic                     adj_bank,
   output logic [DATA_W-1:0]        adj_val,
   output logic                     pop_valid,
   output logic [DATA_W-1:0]        pop_data
);
   localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

   stk_state_e        state_q;
   logic              bank_q;
   logic              is_push_q;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] sp_now;

   assign sp_now = sp_q[sel_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= STK_IDLE;
         bank_q    <= BANK_MAIN;
         is_push_q <= 1'b0;
         addr_q    <= '0;
         data_q    <= '0;
      end else if (state_q == STK_IDLE) begin
         if (push || pop) begin
            state_q   <= STK_BUSY;
            bank_q    <= sel_q;
            is_push_q <= push;
            addr_q    <= push ? (sp_now - STEP) : sp_now;
            data_q    <= wdata;
         end
      end else if (mem_ack) begin
         state_q <= STK_IDLE;
      end
   end

   assign busy      = (state_q == STK_BUSY);
   assign mem_req   = busy;
   assign mem_we    = is_push_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = data_q;
   assign adj_en    = busy && mem_ack;
   assign adj_bank  = bank_q;
   assign adj_val   = is_push_q ? addr_q : (addr_q + STEP);
   assign pop_valid = busy && mem_ack && !is_push_q;
   assign pop_data  = mem_rdata;
endmodule

// File: rtl/banked_rf_pc.sv
module banked_rf_pc #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_pc,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W-1:0]   pc_in,
   output logic [DATA_W-1:0]   pc_read,
   output logic                br_valid,
   output logic [DATA_W-1:0]   br_target,
   output logic                br_fault
);
   localparam logic [DATA_W-1:0] AHEAD = DATA_W'(WORD_BYTES);

   logic [DATA_W-1:0] ahead;
   assign ahead   = pc_in + AHEAD;
   assign pc_read = {ahead[DATA_W-1:1], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_valid  <= 1'b0;
         br_fault  <= 1'b0;
         br_target <= '0;
      end else begin
         br_valid <= wr_pc && wr_data[0];
         br_fault <= wr_pc && !wr_data[0];
         if (wr_pc && wr_data[0]) br_target <= {wr_data[DATA_W-1:1], 1'b0};
      end
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import banked_rf_pkg::*;
#(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       NREG      = 16,
   parameter logic [DATA_W-1:0] MAIN_INIT = DATA_W'(32'h2000_1000),
   parameter logic [DATA_W-1:0] PROC_INIT = DATA_W'(32'h2000_0800),
   localparam int unsigned      ADDR_W    = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sp_sel,
   input  logic [ADDR_W-1:0]   rd_a_idx,
   output logic [DATA_W-1:0]   rd_a_data,
   input  logic [ADDR_W-1:0]   rd_b_idx,
   output logic [DATA_W-1:0]   rd_b_data,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_idx,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W-1:0]   pc_in,
   output logic                br_valid,
   output logic [DATA_W-1:0]   br_target,
   output logic                br_fault,
   input  logic                sys_rsel,
   output logic [DATA_W-1:0]   sys_rdata,
   input  logic                sys_we,
   input  logic                sys_wsel,
   input  logic [DATA_W-1:0]   sys_wdata,
   input  logic                stk_push,
   input  logic                stk_pop,
   input  logic [DATA_W-1:0]   stk_wdata,
   output logic                stk_busy,
   output logic                pop_valid,
   output logic [DATA_W-1:0]   pop_data,
   output logic                mem_req,
   output logic                mem_we,
   output logic [DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_rdata
);
   localparam int unsigned SP_IDX     = NREG - 3;
   localparam int unsigned PC_IDX     = NREG - 1;
   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned ALIGN_W    = $clog2(WORD_BYTES);

   if (NREG < 4 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 4");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 16");
   end

   logic                   sel_q;
   logic [1:0][DATA_W-1:0] sp_q;
   logic [1:0][ADDR_W-1:0] rd_idx;
   logic [1:0][DATA_W-1:0] store_val;
   logic [1:0][DATA_W-1:0] rd_out;
   logic [DATA_W-1:0]      pc_read;
   logic                   wr_sp, wr_pc;
   logic                   adj_en, adj_bank;
   logic [DATA_W-1:0]      adj_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= BANK_MAIN;
      else        sel_q <= sp_sel;
   end

   assign wr_sp = wr_en && wr_idx == ADDR_W'(SP_IDX);
   assign wr_pc = wr_en && wr_idx == ADDR_W'(PC_IDX);

   banked_rf_store #(
      .DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W),
      .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
   ) i_store (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_val(store_val)
   );

   banked_rf_sp #(
      .DATA_W(DATA_W), .ALIGN_W(ALIGN_W),
      .MAIN_INIT(MAIN_INIT), .PROC_INIT(PROC_INIT)
   ) i_sp (
      .clk(clk), .rst_n(rst_n), .sel_q(sel_q),
      .wr_en(wr_sp), .wr_data(wr_data),
      .sys_we(sys_we), .sys_wsel(sys_wsel), .sys_wdata(sys_wdata),
      .adj_en(adj_en), .adj_bank(adj_bank), .adj_val(adj_val),
      .sp_q(sp_q)
   );

   banked_rf_stack #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) i_stack (
      .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
      .wdata(stk_wdata), .sel_q(sel_q), .sp_q(sp_q),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(stk_busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .adj_en(adj_en), .adj_bank(adj_bank),
      .adj_val(adj_val), .pop_valid(pop_valid), .pop_data(pop_data)
   );

   banked_rf_pc #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) i_pc (
      .clk(clk), .rst_n(rst_n), .wr_pc(wr_pc), .wr_data(wr_data),
      .pc_in(pc_in), .pc_read(pc_read), .br_valid(br_valid),
      .br_target(br_target), .br_fault(br_fault)
   );

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;

   for (genvar p = 0; p < 2; p++) begin : g_port
      always_comb begin
         if (rd_idx[p] == ADDR_W'(SP_IDX))      rd_out[p] = sp_q[sel_q];
         else if (rd_idx[p] == ADDR_W'(PC_IDX)) rd_out[p] = pc_read;
         else                                   rd_out[p] = store_val[p];
      end
   end

   assign rd_a_data = rd_out[0];
   assign rd_b_data = rd_out[1];
   assign sys_rdata = sp_q[sys_rsel];
endmodule

// File: rtl/banked_rf_chk.sv
module banked_rf_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned SP_IDX  = 13,
   parameter int unsigned PC_IDX  = 15,
   parameter int unsigned ALIGN_W = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel_q,
   input logic [ADDR_W-1:0]   rd_a_idx,
   input logic [DATA_W-1:0]   rd_a_data,
   input logic [ADDR_W-1:0]   rd_b_idx,
   input logic                rd_b_lsb,
   input logic                sys_rsel,
   input logic [DATA_W-1:0]   sys_rdata,
   input logic                mem_req,
   input logic                mem_ack,
   input logic                mem_we,
   input logic [DATA_W-1:0]   mem_addr,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_idx,
   input logic                wr_lsb,
   input logic                br_valid,
   input logic                br_fault
);
   p_visible_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == ADDR_W'(SP_IDX) && sys_rsel == sel_q) |-> rd_a_data == sys_rdata);

   p_sp_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rdata[ALIGN_W-1:0] == '0);

   p_pc_lsb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_b_idx == ADDR_W'(PC_IDX) |-> !rd_b_lsb);

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_branch_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |-> $past(wr_en && wr_idx == ADDR_W'(PC_IDX) && wr_lsb));

   p_fault_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      br_fault |-> $past(wr_en && wr_idx == ADDR_W'(PC_IDX) && !wr_lsb));

   p_branch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(br_valid && br_fault));
endmodule

bind banked_regfile banked_rf_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SP_IDX(SP_IDX),
   .PC_IDX(PC_IDX), .ALIGN_W(ALIGN_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .sel_q(sel_q),
   .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
   .rd_b_idx(rd_b_idx), .rd_b_lsb(rd_b_data[0]),
   .sys_rsel(sys_rsel), .sys_rdata(sys_rdata),
   .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
   .wr_en(wr_en), .wr_idx(wr_idx), .wr_lsb(wr_data[0]),
   .br_valid(br_valid), .br_fault(br_fault)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
   localparam time         CLK_P     = 5ns;
   localparam logic [31:0] MAIN_INIT = 32'h2000_1000;
   localparam logic [31:0] PROC_INIT = 32'h2000_0800;

   typedef struct packed {
      logic [3:0]  idx;
      logic [31:0] val;
   } wvec_t;

   localparam wvec_t VEC [6] = '{
      '{4'd0,  32'hDEAD_0000},
      '{4'd3,  32'h0000_0003},
      '{4'd5,  32'hA5A5_5A5A},
      '{4'd7,  32'hFFFF_FFFF},
      '{4'd12, 32'h1234_5678},
      '{4'd14, 32'h0000_1235}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sp_sel;
   logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
   logic [31:0] rd_a_data, rd_b_data, wr_data, pc_in, br_target;
   logic        wr_en, br_valid, br_fault;
   logic        sys_rsel, sys_we, sys_wsel;
   logic [31:0] sys_rdata, sys_wdata;
   logic        stk_push, stk_pop, stk_busy, pop_valid;
   logic [31:0] stk_wdata, pop_data;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [31:0] mem [256];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_P / 2) clk = ~clk;

   banked_regfile #(.MAIN_INIT(MAIN_INIT), .PROC_INIT(PROC_INIT)) i_banked_regfile (
      .clk(clk), .rst_n(rst_n), .sp_sel(sp_sel),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pc_in(pc_in), .br_valid(br_valid), .br_target(br_target), .br_fault(br_fault),
      .sys_rsel(sys_rsel), .sys_rdata(sys_rdata),
      .sys_we(sys_we), .sys_wsel(sys_wsel), .sys_wdata(sys_wdata),
      .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
      .stk_busy(stk_busy), .pop_valid(pop_valid), .pop_data(pop_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: acknowledge one cycle after a request appears
   assign mem_rdata = mem[mem_addr[9:2]];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd_sys(input logic which, output logic [31:0] v);
      sys_rsel = which;
      #0.5;
      v = sys_rdata;
   endtask

   logic [31:0] v;

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      rst_n = 1'b0; sp_sel = 1'b0; rd_a_idx = '0; rd_b_idx = '0;
      wr_en = 1'b0; wr_idx = '0; wr_data = '0; pc_in = '0;
      sys_rsel = 1'b0; sys_we = 1'b0; sys_wsel = 1'b0; sys_wdata = '0;
      stk_push = 1'b0; stk_pop = 1'b0; stk_wdata = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd_a_idx = 4'd13; #0.5;
      chk("R1 visible sp after reset", rd_a_data, MAIN_INIT);
      rd_sys(1'b0, v); chk("R1 main copy reset", v, MAIN_INIT);
      rd_sys(1'b1, v); chk("R1 process copy reset", v, PROC_INIT);
      chk("R1 no branch strobe", {30'd0, br_valid, br_fault}, 32'd0);

      // R2 table of writes, then read back on both ports
      foreach (VEC[k]) begin
         wr_en = 1'b1; wr_idx = VEC[k].idx; wr_data = VEC[k].val;
         tick();
      end
      wr_en = 1'b0;
      foreach (VEC[k]) begin
         rd_a_idx = VEC[k].idx; rd_b_idx = VEC[k].idx; #0.5;
         chk($sformatf("R2 port a idx %0d", VEC[k].idx), rd_a_data, VEC[k].val);
         chk($sformatf("R2 port b idx %0d", VEC[k].idx), rd_b_data, VEC[k].val);
      end

      // R3 select takes effect at the edge
      rd_a_idx = 4'd13;
      sp_sel = 1'b1; #0.5;
      chk("R3 select before edge", rd_a_data, MAIN_INIT);
      tick();
      chk("R3 select after edge", rd_a_data, PROC_INIT);
      // R5 normal write to process copy drops low bits
      wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h2000_0907;
      tick();
      wr_en = 1'b0; #0.5;
      chk("R5 write ignores bits 1:0", rd_a_data, 32'h2000_0904);
      rd_sys(1'b0, v); chk("R3 main untouched by process write", v, MAIN_INIT);
      sp_sel = 1'b0;
      tick();

      // R4 side port writes the inactive copy
      sys_we = 1'b1; sys_wsel = 1'b1; sys_wdata = 32'h2000_0A03;
      tick();
      sys_we = 1'b0;
      rd_sys(1'b1, v); chk("R4 side write process copy", v, 32'h2000_0A00);
      chk("R4 active main unchanged", rd_a_data, MAIN_INIT);

      // R6 push on main
      stk_push = 1'b1; stk_wdata = 32'hCAFE_0001;
      tick();
      stk_push = 1'b0;
      chk("R6 push request", {29'd0, mem_req, mem_we, stk_busy}, 32'd7);
      chk("R6 push address", mem_addr, 32'h2000_0FFC);
      chk("R6 push data", mem_wdata, 32'hCAFE_0001);
      tick();
      chk("R6 pointer held until ack", rd_a_data, MAIN_INIT);
      tick();
      chk("R6 pointer after push", rd_a_data, 32'h2000_0FFC);
      chk("R6 word stored", mem[10'h3FC >> 2], 32'hCAFE_0001);

      // R7 pop on main
      stk_pop = 1'b1;
      tick();
      stk_pop = 1'b0;
      chk("R7 pop address", mem_addr, 32'h2000_0FFC);
      chk("R7 pop is read", {31'd0, mem_we}, 32'd0);
      tick();
      chk("R7 pop valid", {31'd0, pop_valid}, 32'd1);
      chk("R7 pop data", pop_data, 32'hCAFE_0001);
      tick();
      chk("R7 pointer after pop", rd_a_data, MAIN_INIT);
      chk("R7 pop valid drops", {31'd0, pop_valid}, 32'd0);

      // R8 select flips while a push is outstanding
      stk_push = 1'b1; stk_wdata = 32'h0000_0011;
      tick();
      stk_push = 1'b0; sp_sel = 1'b1;
      tick();
      tick();
      rd_sys(1'b0, v); chk("R8 push stays on main", v, 32'h2000_0FFC);
      rd_sys(1'b1, v); chk("R8 process copy untouched", v, 32'h2000_0A00);
      chk("R8 visible copy now process", rd_a_data, 32'h2000_0A00);
      sp_sel = 1'b0;
      tick();

      // R9 pointer update beats colliding writes in the ack cycle
      stk_push = 1'b1; stk_wdata = 32'h0000_0022;
      tick();
      stk_push = 1'b0;
      tick();
      wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h1234_5678;
      sys_we = 1'b1; sys_wsel = 1'b0; sys_wdata = 32'h5555_5554;
      tick();
      wr_en = 1'b0; sys_we = 1'b0;
      rd_sys(1'b0, v); chk("R9 update wins collision", v, 32'h2000_0FF8);

      // R10 program counter reads
      rd_b_idx = 4'd15; pc_in = 32'h0000_1000; #0.5;
      chk("R10 pc read", rd_b_data, 32'h0000_1004);
      pc_in = 32'h0000_1003; #0.5;
      chk("R10 pc read bit0 clear", rd_b_data, 32'h0000_1006);

      // R11 good branch target
      wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_2001;
      tick();
      wr_en = 1'b0;
      chk("R11 branch strobes", {30'd0, br_valid, br_fault}, 32'd2);
      chk("R11 branch target", br_target, 32'h0000_2000);
      rd_a_idx = 4'd14; #0.5;
      chk("R11 link unchanged", rd_a_data, 32'h0000_1235);
      tick();
      chk("R11 strobe one cycle", {31'd0, br_valid}, 32'd0);

      // R12 bad branch target
      wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_3000;
      tick();
      wr_en = 1'b0;
      chk("R12 fault strobes", {30'd0, br_valid, br_fault}, 32'd1);
      tick();
      chk("R12 fault one cycle", {31'd0, br_fault}, 32'd0);

      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule